// File: doc/BRIEF.md
# Paired-Float Compare into Condition Field

This block executes the floating-point compare group of a signal-processing instruction extension. Each start pulse brings a 32-bit instruction word and two 64-bit source register values. The block decodes the instruction, runs a greater-than, less-than or equal test, and writes a 4-bit result into one nibble of a 32-bit condition register that it holds itself. The other seven nibbles are left as they were. In the same cycle it sets or clears an invalid-operation flag.

A compare can use one of three operand formats. Scalar single precision reads only the low 32 bits of each source. Scalar double precision reads the full 64-bit value. The paired form runs two single-precision compares side by side, one on the upper word and one on the lower word, and packs both outcomes into the nibble. Results are ready one cycle after start, marked by a one-cycle done pulse. A word that does not decode as one of the nine compare forms is reported as illegal and changes nothing.

Top module: `fcmp_cr_unit`

## Requirements
- R1: When start is accepted, done pulses for the next cycle only. The condition register and the flag change only on a done cycle.
- R2: A word is a legal compare only when both of these hold. Bits 31:26 equal 4. Bits 10:0 equal 0x2CC, 0x2CD or 0x2CE (single), 0x2EC, 0x2ED or 0x2EE (double), or 0x28C, 0x28D or 0x28E (paired). Any other word raises illegal together with done, and both the condition register and the flag keep their previous values.
- R3: Bits 7:5 of the word set the format: 6 is scalar single, 7 is scalar double, 4 is paired. The two low bits of the function code set the test: 0 is A>B, 1 is A<B, 2 is A==B.
- R4: Scalar single compares bits 31:0 of the two sources and ignores bits 63:32. The written nibble is 4'b0100 if the test holds and 4'b0000 if it does not.
- R5: Scalar double compares all 64 bits of each source (11-bit exponent, 52-bit fraction), so a difference in the low word alone decides the result.
- R6: In paired mode, let hi be the outcome on bits 63:32 and lo the outcome on bits 31:0. The nibble is {hi, lo, hi|lo, hi&lo}, from bit 3 down to bit 0.
- R7: Bits 25:23 give the field index f. The nibble is written to condition bits [(7-f)*4+3 : (7-f)*4], so field 0 is bits 31:28. All other bits are preserved.
- R8: A NaN (exponent all ones, fraction nonzero) in either compared operand makes every test false. Two identical NaNs are not equal.
- R9: The invalid flag is set only when a compared operand is a signaling NaN, meaning the fraction MSB is 0. Quiet NaNs never set it.
- R10: Each legal compare replaces the flag with its own result, so a clean compare clears a flag left by an earlier one.
- R11: +0 and -0 compare equal. Ordering follows sign and magnitude, so -2.0 < -1.0 and any negative nonzero value is below any positive value.
- R12: After reset the condition register is 0, and the flag, done and illegal are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid for one cycle |
| insn | input | 32 | Instruction word |
| src_a | input | 64 | First source register value |
| src_b | input | 64 | Second source register value |
| done | output | 1 | One-cycle pulse, one cycle after start |
| illegal | output | 1 | High with done when the word was not a legal compare |
| cr | output | 32 | Condition register, eight 4-bit fields |
| inv_flag | output | 1 | Invalid-operation flag from the last legal compare |

## Verification
The bench builds the block with its default parameters: 8/23 single lanes, an 11/52 double lane and eight 4-bit condition fields. With these values each field position can be written, and the bench checks all eight to show that the other fields are preserved. The same defaults exercise the signaling/quiet split at the fraction MSB in both widths. They also let the bench put a signaling NaN in an ignored upper word, and build double-precision values that differ only in the low word.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

   typedef enum logic [2:0] {
      FMT_PAIR = 3'd4,
      FMT_SGL  = 3'd6,
      FMT_DBL  = 3'd7
   } fmt_e;

   typedef enum logic [1:0] {
      TST_GT = 2'd0,
      TST_LT = 2'd1,
      TST_EQ = 2'd2
   } tst_e;

   typedef struct packed {
      logic       ok;
      fmt_e       fmt;
      tst_e       tst;
      logic [2:0] fld;
   } fdec_t;

   localparam logic [5:0] GROUP_OPC = 6'd4;

   function automatic logic pick_test(input tst_e t, input logic gt,
                                      input logic lt, input logic eq);
      case (t)
         TST_GT:  return gt;
         TST_LT:  return lt;
         default: return eq;
      endcase
   endfunction

endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
   import fcmp_pkg::*;
(
   input  logic [31:0] insn,
   output fdec_t       dec
);
   logic [10:0] fn;
   logic        grp_ok, fn_ok, fmt_ok;

   assign fn     = insn[10:0];
   assign grp_ok = (insn[31:26] == GROUP_OPC);
   // family 0x2xC..0x2xE: upper bits 010, bit4 clear, bits 3:2 set, low pair not 11
   assign fn_ok  = (fn[10:8] == 3'b010) && !fn[4] && (fn[3:2] == 2'b11) &&
                   (fn[1:0] != 2'b11);
   assign fmt_ok = (fn[7:5] == FMT_PAIR) || (fn[7:5] == FMT_SGL) ||
                   (fn[7:5] == FMT_DBL);

   logic unused_idx;
   assign unused_idx = ^insn[22:11];

   always_comb begin
      dec.ok  = grp_ok && fn_ok && fmt_ok;
      dec.fmt = fmt_e'(fn[7:5]);
      dec.tst = tst_e'(fn[1:0]);
      dec.fld = insn[25:23];
   end
endmodule

// File: rtl/fcmp_lane.sv
module fcmp_lane #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] a,
   input  logic [EXP_W+FRAC_W:0] b,
   output logic                  gt,
   output logic                  lt,
   output logic                  eq,
   output logic                  sig_nan
);
   localparam int W     = 1 + EXP_W + FRAC_W;
   localparam int MAG_W = W - 1;

   logic             a_nan, b_nan, a_snan, b_snan, unord;
   logic [MAG_W-1:0] mag_a, mag_b;
   logic             sa, sb, both_zero, a_below, b_below;

   assign sa     = a[W-1];
   assign sb     = b[W-1];
   assign mag_a  = a[MAG_W-1:0];
   assign mag_b  = b[MAG_W-1:0];
   assign a_nan  = (&a[W-2:FRAC_W]) && (|a[FRAC_W-1:0]);
   assign b_nan  = (&b[W-2:FRAC_W]) && (|b[FRAC_W-1:0]);
   assign a_snan = a_nan && !a[FRAC_W-1];
   assign b_snan = b_nan && !b[FRAC_W-1];
   assign unord  = a_nan || b_nan;
   assign both_zero = (mag_a == '0) && (mag_b == '0);

   always_comb begin
      if (both_zero)      a_below = 1'b0;
      else if (sa != sb)  a_below = sa;
      else if (!sa)       a_below = (mag_a < mag_b);
      else                a_below = (mag_a > mag_b);
   end

   always_comb begin
      if (both_zero)      b_below = 1'b0;
      else if (sa != sb)  b_below = sb;
      else if (!sb)       b_below = (mag_b < mag_a);
      else                b_below = (mag_b > mag_a);
   end

   assign lt      = !unord && a_below;
   assign gt      = !unord && b_below;
   assign eq      = !unord && (both_zero || (a == b));
   assign sig_nan = a_snan || b_snan;
endmodule

// File: rtl/fcmp_cr_unit.sv
module fcmp_cr_unit
   import fcmp_pkg::*;
#(
   parameter int CR_FIELDS = 8,
   parameter int NIB_W     = 4,
   parameter int LANES     = 2,
   parameter int SP_EXP    = 8,
   parameter int SP_FRAC   = 23,
   parameter int DP_EXP    = 11,
   parameter int DP_FRAC   = 52
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [31:0] insn,
   input  logic [63:0] src_a,
   input  logic [63:0] src_b,
   output logic        done,
   output logic        illegal,
   output logic [31:0] cr,
   output logic        inv_flag
);
   localparam int SP_W  = 1 + SP_EXP + SP_FRAC;
   localparam int DP_W  = 1 + DP_EXP + DP_FRAC;
   localparam int REG_W = LANES * SP_W;
   localparam int CR_W  = CR_FIELDS * NIB_W;
   localparam int FLD_W = $clog2(CR_FIELDS);

   if (REG_W != 64 || DP_W != REG_W) begin : g_bad_width
      $error("double width must fill the 64-bit register split into lanes");
   end
   if (LANES != 2) begin : g_bad_lanes
      $error("paired mode needs exactly two lanes");
   end
   if (CR_FIELDS != 8 || NIB_W != 4 || CR_W != 32) begin : g_bad_cr
      $error("condition register must be eight 4-bit fields");
   end

   fdec_t dec;
   fcmp_decode u_dec (.insn(insn), .dec(dec));

   logic [LANES-1:0] l_gt, l_lt, l_eq, l_snan, l_hit;
   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      fcmp_lane #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
         .a(src_a[gl*SP_W +: SP_W]), .b(src_b[gl*SP_W +: SP_W]),
         .gt(l_gt[gl]), .lt(l_lt[gl]), .eq(l_eq[gl]), .sig_nan(l_snan[gl])
      );
      assign l_hit[gl] = pick_test(dec.tst, l_gt[gl], l_lt[gl], l_eq[gl]);
   end

   logic d_gt, d_lt, d_eq, d_snan, d_hit;
   fcmp_lane #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
      .a(src_a[DP_W-1:0]), .b(src_b[DP_W-1:0]),
      .gt(d_gt), .lt(d_lt), .eq(d_eq), .sig_nan(d_snan)
   );
   assign d_hit = pick_test(dec.tst, d_gt, d_lt, d_eq);

   logic [NIB_W-1:0] nib_d;
   logic             inv_d;
   always_comb begin
      case (dec.fmt)
         FMT_PAIR: begin
            nib_d = {l_hit[1], l_hit[0], l_hit[1] | l_hit[0], l_hit[1] & l_hit[0]};
            inv_d = |l_snan;
         end
         FMT_DBL: begin
            nib_d = {1'b0, d_hit, 2'b00};
            inv_d = d_snan;
         end
         default: begin
            nib_d = {1'b0, l_hit[0], 2'b00};
            inv_d = l_snan[0];
         end
      endcase
   end

   logic [CR_W-1:0] cr_q, cr_d;
   for (genvar gf = 0; gf < CR_FIELDS; gf++) begin : g_field
      localparam int POS = (CR_FIELDS - 1 - gf) * NIB_W;
      assign cr_d[POS +: NIB_W] = (dec.fld == FLD_W'(gf)) ? nib_d
                                                         : cr_q[POS +: NIB_W];
   end

   logic             done_q, illegal_q, inv_q;
   fmt_e             fmt_q;
   logic [FLD_W-1:0] fld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cr_q      <= '0;
         inv_q     <= 1'b0;
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
         fmt_q     <= FMT_SGL;
         fld_q     <= '0;
      end else begin
         done_q    <= start;
         illegal_q <= start && !dec.ok;
         if (start && dec.ok) begin
            cr_q  <= cr_d;
            inv_q <= inv_d;
            fmt_q <= dec.fmt;
            fld_q <= dec.fld;
         end
      end
   end

   assign done     = done_q;
   assign illegal  = illegal_q;
   assign cr       = cr_q;
   assign inv_flag = inv_q;

   // ---------------- checks ----------------
   logic [CR_W-1:0]  chk_mask;
   logic [NIB_W-1:0] chk_nib;
   always_comb begin
      chk_mask = '0;
      chk_nib  = '0;
      for (int f = 0; f < CR_FIELDS; f++) begin
         if (fld_q == FLD_W'(f)) begin
            chk_mask[(CR_FIELDS-1-f)*NIB_W +: NIB_W] = '1;
            chk_nib = cr_q[(CR_FIELDS-1-f)*NIB_W +: NIB_W];
         end
      end
   end

   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
   assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);
   assert_quiet_between_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(cr_q) && $stable(inv_q)));
   assert_illegal_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_q |-> ($stable(cr_q) && $stable(inv_q)));
   assert_scalar_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !illegal_q && fmt_q != FMT_PAIR) |-> ((chk_nib & 4'b1011) == 4'b0000));
   assert_pair_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !illegal_q && fmt_q == FMT_PAIR) |->
      (chk_nib[1] == (chk_nib[3] | chk_nib[2]) && chk_nib[0] == (chk_nib[3] & chk_nib[2])));
   assert_one_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !illegal_q) |-> (((cr_q ^ $past(cr_q)) & ~chk_mask) == '0));
endmodule

// File: tb/fcmp_cr_unit_tb.sv
module fcmp_cr_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] insn = '0;
   logic [63:0] src_a = '0, src_b = '0;
   logic        done, illegal, inv_flag;
   logic [31:0] cr;

   int n_chk = 0, n_fail = 0;
   logic finished = 1'b0;
   logic [31:0] exp_cr = '0;

   always #5 clk = ~clk;

   fcmp_cr_unit u_dut (.clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
      .src_a(src_a), .src_b(src_b), .done(done), .illegal(illegal),
      .cr(cr), .inv_flag(inv_flag));

   localparam logic [10:0] SGT = 11'h2CC, SLT = 11'h2CD, SEQ = 11'h2CE;
   localparam logic [10:0] DGT = 11'h2EC, DLT = 11'h2ED, DEQ = 11'h2EE;
   localparam logic [10:0] VGT = 11'h28C, VLT = 11'h28D, VEQ = 11'h28E;
   localparam logic [31:0] S1 = 32'h3F800000, S2 = 32'h40000000;
   localparam logic [31:0] SM1 = 32'hBF800000, SM2 = 32'hC0000000;
   localparam logic [31:0] SPZ = 32'h0, SMZ = 32'h80000000;
   localparam logic [31:0] SQN = 32'h7FC00000, SSN = 32'h7F800001;
   localparam logic [63:0] D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000;
   localparam logic [63:0] DM3 = 64'hC008000000000000;
   localparam logic [63:0] DSN = 64'h7FF0000000000001;

   function automatic logic [31:0] mk(input logic [10:0] fn, input logic [2:0] fld);
      return {6'd4, fld, 2'b00, 5'd1, 5'd2, fn};
   endfunction

   function automatic logic [31:0] put(input logic [31:0] c, input logic [2:0] fld,
                                       input logic [3:0] nib);
      logic [31:0] r = c;
      r[(7-int'(fld))*4 +: 4] = nib;
      return r;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      start = 1'b1; insn = i; src_a = a; src_b = b;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic cmp_case(input string tag, input logic [10:0] fn, input logic [2:0] fld,
                           input logic [63:0] a, input logic [63:0] b,
                           input logic [3:0] nib, input logic inv);
      issue(mk(fn, fld), a, b);
      exp_cr = put(exp_cr, fld, nib);
      chk({tag, " done"}, done, 1);
      chk({tag, " cr"}, cr, exp_cr);
      chk({tag, " inv"}, inv_flag, inv);
   endtask

   task automatic t_reset;
      chk("R12 cr", cr, 0);
      chk("R12 inv", inv_flag, 0);
      chk("R12 done", done, 0);
      chk("R12 illegal", illegal, 0);
   endtask

   task automatic t_single;
      cmp_case("R4 gt", SGT, 3'd0, {32'h0, S2}, {32'h0, S1}, 4'b0100, 0);
      @(negedge clk);
      chk("R1 done drops", done, 0);
      cmp_case("R4 lt false", SLT, 3'd0, {32'h0, S2}, {32'h0, S1}, 4'b0000, 0);
      cmp_case("R3 eq", SEQ, 3'd7, {32'h0, S1}, {32'h0, S1}, 4'b0100, 0);
      // upper word holds a signaling NaN and differs: must be ignored
      cmp_case("R4 upper ignored", SLT, 3'd2, {SSN, S1}, {32'h12345678, S2}, 4'b0100, 0);
   endtask

   task automatic t_order;
      cmp_case("R11 neg lt", SLT, 3'd1, {32'h0, SM2}, {32'h0, SM1}, 4'b0100, 0);
      cmp_case("R11 neg gt", SGT, 3'd1, {32'h0, SM1}, {32'h0, SM2}, 4'b0100, 0);
      cmp_case("R11 zeros eq", SEQ, 3'd3, {32'h0, SPZ}, {32'h0, SMZ}, 4'b0100, 0);
      cmp_case("R11 zeros not lt", SLT, 3'd3, {32'h0, SMZ}, {32'h0, SPZ}, 4'b0000, 0);
      cmp_case("R11 pos gt neg", SGT, 3'd4, {32'h0, S1}, {32'h0, SM2}, 4'b0100, 0);
   endtask

   task automatic t_double;
      cmp_case("R5 low word decides", DLT, 3'd5, D1, D1 | 64'h1, 4'b0100, 0);
      cmp_case("R5 eq", DEQ, 3'd5, DM3, DM3, 4'b0100, 0);
      cmp_case("R5 gt", DGT, 3'd6, D2, DM3, 4'b0100, 0);
   endtask

   task automatic t_pair;
      cmp_case("R6 gt hi only", VGT, 3'd0, {S2, S1}, {S1, S2}, 4'b1010, 0);
      cmp_case("R6 lt lo only", VLT, 3'd0, {S2, S1}, {S1, S2}, 4'b0110, 0);
      cmp_case("R6 eq both", VEQ, 3'd1, {S1, SM1}, {S1, SM1}, 4'b1111, 0);
      cmp_case("R6 eq none", VEQ, 3'd1, {S1, S2}, {S2, S1}, 4'b0000, 0);
   endtask

   task automatic t_nan;
      cmp_case("R8 qnan eq self", SEQ, 3'd2, {32'h0, SQN}, {32'h0, SQN}, 4'b0000, 0);
      cmp_case("R9 snan lt", SLT, 3'd2, {32'h0, SSN}, {32'h0, S1}, 4'b0000, 1);
      cmp_case("R10 flag replaced", SEQ, 3'd2, {32'h0, S1}, {32'h0, S1}, 4'b0100, 0);
      cmp_case("R9 double snan", DGT, 3'd6, D1, DSN, 4'b0000, 1);
      cmp_case("R9 qnan no flag", DEQ, 3'd6, 64'h7FF8000000000000, D1, 4'b0000, 0);
      cmp_case("R8 pair hi snan", VEQ, 3'd4, {SSN, S1}, {SSN, S1}, 4'b0110, 1);
   endtask

   task automatic t_illegal;
      logic [31:0] bad;
      bad = mk(SEQ, 3'd0);
      bad[31:26] = 6'd5;
      issue(bad, {32'h0, S1}, {32'h0, S1});
      chk("R2 bad opcode done", done, 1);
      chk("R2 bad opcode illegal", illegal, 1);
      chk("R2 bad opcode cr", cr, exp_cr);
      chk("R2 bad opcode inv", inv_flag, 1);
      issue(mk(11'h2CF, 3'd0), {32'h0, S1}, {32'h0, S1});
      chk("R2 bad func illegal", illegal, 1);
      chk("R2 bad func cr", cr, exp_cr);
      chk("R2 bad func inv", inv_flag, 1);
   endtask

   task automatic t_fields;
      for (int f = 0; f < 8; f++) begin
         if (f % 2 == 0)
            cmp_case("R7 field eq", VEQ, 3'(f), {S1, S1}, {S1, S1}, 4'b1111, 0);
         else
            cmp_case("R7 field gt", VGT, 3'(f), {S2, S1}, {S1, S2}, 4'b1010, 0);
      end
      chk("R7 whole register", cr, 32'hFAFAFAFA);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_single();
      t_order();
      t_double();
      t_pair();
      t_nan();
      t_illegal();
      t_fields();
      @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule